// File: doc/BRIEF.md
# Serial Sampling-Converter Slave Interface

This block is the digital side of a multi-channel 12-bit sampling converter seen from its four-wire serial port. A host lowers the active-low select, toggles the serial clock and, on each frame of sixteen clock cycles, receives one conversion result while it shifts in a command byte. The command picks which of the parallel sample inputs is captured in the next frame. The parallel inputs stand in for the analog channels. At the hold point of each frame the selected word is captured and then shifted out behind a run of leading zeros.

The serial clock, select and data input are asynchronous to the block's own clock. They are synchronised and edge-detected, and all sequencing runs on the system clock. Frames repeat back to back for as long as select stays low. Raising select at any point abandons the frame in progress. A one-cycle strobe and the index of the channel being converted are brought out at every hold point.

Top module: `sar_serial_slave`

## Requirements
- R1: A frame spans 16 serial-clock falling edges. While select stays low the 17th falling edge is the first of the next frame, with no gap.
- R2: Per frame, `dout` carries 16 bits MSB first: 4 zeros, then the 12-bit captured word from bit 11 down to bit 0. A bit changes only after a detected falling edge and is steady up to the following rising edge.
- R3: The command byte is read MSB first from `din` on rising edges 1 to 8 of a frame. `din` has no effect on rising edges 9 to 16.
- R4: Command bits 5:3 form the channel code, and bits 7, 6, 2, 1 and 0 have no effect. Code k from 0 to 6 selects `chan_data[k*12+11 : k*12]`. Code 7 selects ground and yields a result of 0.
- R5: A channel code received in one frame governs the capture in the next frame, and the frame carrying it still converts the previous code.
- R6: After reset the channel code is 0, so the first frame converts `chan_data[11:0]`.
- R7: The word is captured on falling edge 4 of the frame, and input changes after that edge do not alter the result. `smp_strobe` is high for exactly one clock cycle per frame at that point, and `smp_chan` then shows the code that was used.
- R8: While select is high, `dout_oe` is 0, `dout` is 0, and serial-clock and `din` activity has no effect.
- R9: If the serial clock is low when select falls, the select fall is falling edge 1. If the clock is high, the next clock fall is edge 1.
- R10: Raising select in mid-frame resets the frame position. A partly received command is discarded and the previous channel code stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select that frames transfers |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial command input |
| chan_data | input | NUM_INPUTS*DATA_W | Parallel sample words, channel k at bits k*DATA_W upward |
| dout | output | 1 | Serial result output |
| dout_oe | output | 1 | Output enable for `dout` |
| smp_strobe | output | 1 | One-cycle pulse at the hold point |
| smp_chan | output | ADDR_W | Channel code of the current capture |

## Verification
The bound checker watches, on every cycle, that the output stays quiet and disabled outside a frame and that `dout` moves only after a detected falling edge. It also checks that the channel code changes only on a rising edge, that the strobe is a lone pulse following a falling edge, and that the reported channel matches the code held just before it. The bench alone can show the arithmetic content of each shifted word and the one-frame select latency. It also covers capture at exactly the fourth falling edge, the effect of the idle clock level at select fall, the discarding of an aborted command, and immunity to data on the late rising edges. It sweeps every channel code in both continuous and separate frames.

// File: rtl/sss_pkg.sv
package sss_pkg;

  // Decoded serial events, all in the system-clock domain.
  typedef struct packed {
    logic act;   // select is low (synchronised)
    logic fall;  // falling edge of the frame clock (includes select-fall case)
    logic rise;  // rising edge of the frame clock
    logic din;   // synchronised serial input, aligned with the clock events
  } ser_evt_t;

endpackage

// File: rtl/sss_edge_detect.sv
module sss_edge_detect
  import sss_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cs_n,
  input  logic     sclk,
  input  logic     din,
  output ser_evt_t evt
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] cs_sync, sclk_sync, din_sync;
  logic                   cs_prev, sclk_prev;
  logic                   cs_s, sclk_s, cs_fell;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sync   <= '1;
      sclk_sync <= '0;
      din_sync  <= '0;
      cs_prev   <= 1'b1;
      sclk_prev <= 1'b0;
    end else begin
      cs_sync   <= {cs_sync[SYNC_STAGES-2:0], cs_n};
      sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], sclk};
      din_sync  <= {din_sync[SYNC_STAGES-2:0], din};
      cs_prev   <= cs_sync[LAST];
      sclk_prev <= sclk_sync[LAST];
    end
  end

  always_comb begin
    cs_s     = cs_sync[LAST];
    sclk_s   = sclk_sync[LAST];
    cs_fell  = cs_prev & ~cs_s;
    evt.act  = ~cs_s;
    // A select fall with the clock low stands in for the first falling edge.
    evt.fall = ~cs_s & ((sclk_prev & ~sclk_s) | (cs_fell & ~sclk_s));
    evt.rise = ~cs_s & ~cs_fell & ~sclk_prev & sclk_s;
    evt.din  = din_sync[LAST];
  end

endmodule

// File: rtl/sss_cmd_reg.sv
module sss_cmd_reg #(
  parameter int FRAME_LEN = 16,
  parameter int CMD_W     = 8,
  parameter int ADDR_LSB  = 3,
  parameter int ADDR_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act,
  input  logic              rise,
  input  logic              din,
  output logic [ADDR_W-1:0] addr
);

  localparam int CNT_W    = $clog2(FRAME_LEN);
  // Rise index (0-based) at which the field's top and bottom bits arrive.
  localparam int FIRST_RI = CMD_W - 1 - (ADDR_LSB + ADDR_W - 1);
  localparam int LAST_RI  = CMD_W - 1 - ADDR_LSB;

  logic [CNT_W-1:0]  rcnt_q, rcnt_n;
  logic [ADDR_W-1:0] shr_q, shr_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              in_field;

  always_comb begin
    in_field = (rcnt_q >= CNT_W'(FIRST_RI)) && (rcnt_q <= CNT_W'(LAST_RI));
    rcnt_n   = rcnt_q;
    shr_n    = shr_q;
    addr_n   = addr_q;
    if (!act) begin
      rcnt_n = '0;
    end else if (rise) begin
      if (in_field) shr_n = {shr_q[ADDR_W-2:0], din};
      if (rcnt_q == CNT_W'(CMD_W - 1)) addr_n = shr_n;
      rcnt_n = (rcnt_q == CNT_W'(FRAME_LEN - 1)) ? '0 : rcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt_q <= '0;
      shr_q  <= '0;
      addr_q <= '0;
    end else begin
      rcnt_q <= rcnt_n;
      shr_q  <= shr_n;
      addr_q <= addr_n;
    end
  end

  assign addr = addr_q;

endmodule

// File: rtl/sss_conv_seq.sv
module sss_conv_seq #(
  parameter int FRAME_LEN  = 16,
  parameter int DATA_W     = 12,
  parameter int NUM_INPUTS = 7,
  parameter int ADDR_W     = 3,
  parameter int HOLD_FALL  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         act,
  input  logic                         fall,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [NUM_INPUTS*DATA_W-1:0] chan_data,
  output logic                         dout,
  output logic                         dout_oe,
  output logic                         smp_strobe,
  output logic [ADDR_W-1:0]            smp_chan
);

  localparam int CNT_W = $clog2(FRAME_LEN);
  localparam int LEAD  = FRAME_LEN - DATA_W;

  logic [CNT_W-1:0]  fcnt_q, fcnt_n;
  logic [DATA_W-1:0] shf_q, shf_n;
  logic [DATA_W-1:0] sel_word;
  logic [ADDR_W-1:0] chan_q, chan_n;
  logic              dout_q, dout_n;
  logic              oe_q, oe_n;
  logic              stb_q, stb_n;

  // Channel mux: codes beyond the last input read as ground (zero).
  always_comb begin
    sel_word = '0;
    for (int k = 0; k < NUM_INPUTS; k++) begin
      if (addr == ADDR_W'(k)) sel_word = chan_data[k*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    fcnt_n = fcnt_q;
    shf_n  = shf_q;
    chan_n = chan_q;
    dout_n = dout_q;
    oe_n   = act;
    stb_n  = 1'b0;
    if (!act) begin
      fcnt_n = '0;
      dout_n = 1'b0;
    end else if (fall) begin
      if (fcnt_q < CNT_W'(LEAD)) begin
        dout_n = 1'b0;
      end else begin
        dout_n = shf_q[DATA_W-1];
        shf_n  = {shf_q[DATA_W-2:0], 1'b0};
      end
      if (fcnt_q == CNT_W'(HOLD_FALL - 1)) begin
        shf_n  = sel_word;
        chan_n = addr;
        stb_n  = 1'b1;
      end
      fcnt_n = (fcnt_q == CNT_W'(FRAME_LEN - 1)) ? '0 : fcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt_q <= '0;
      shf_q  <= '0;
      chan_q <= '0;
      dout_q <= 1'b0;
      oe_q   <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      fcnt_q <= fcnt_n;
      shf_q  <= shf_n;
      chan_q <= chan_n;
      dout_q <= dout_n;
      oe_q   <= oe_n;
      stb_q  <= stb_n;
    end
  end

  assign dout       = dout_q;
  assign dout_oe    = oe_q;
  assign smp_strobe = stb_q;
  assign smp_chan   = chan_q;

endmodule

// File: rtl/sar_serial_slave.sv
module sar_serial_slave
  import sss_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int FRAME_LEN   = 16,
  parameter int NUM_INPUTS  = 7,
  parameter int CMD_W       = 8,
  parameter int ADDR_LSB    = 3,
  parameter int ADDR_W      = 3,
  parameter int HOLD_FALL   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cs_n,
  input  logic                         sclk,
  input  logic                         din,
  input  logic [NUM_INPUTS*DATA_W-1:0] chan_data,
  output logic                         dout,
  output logic                         dout_oe,
  output logic                         smp_strobe,
  output logic [ADDR_W-1:0]            smp_chan
);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  ser_evt_t          evt;
  logic [ADDR_W-1:0] cur_addr;

  // Reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  sss_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .cs_n  (cs_n),
    .sclk  (sclk),
    .din   (din),
    .evt   (evt)
  );

  sss_cmd_reg #(
    .FRAME_LEN (FRAME_LEN),
    .CMD_W     (CMD_W),
    .ADDR_LSB  (ADDR_LSB),
    .ADDR_W    (ADDR_W)
  ) u_cmd (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .act   (evt.act),
    .rise  (evt.rise),
    .din   (evt.din),
    .addr  (cur_addr)
  );

  sss_conv_seq #(
    .FRAME_LEN  (FRAME_LEN),
    .DATA_W     (DATA_W),
    .NUM_INPUTS (NUM_INPUTS),
    .ADDR_W     (ADDR_W),
    .HOLD_FALL  (HOLD_FALL)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .act        (evt.act),
    .fall       (evt.fall),
    .addr       (cur_addr),
    .chan_data  (chan_data),
    .dout       (dout),
    .dout_oe    (dout_oe),
    .smp_strobe (smp_strobe),
    .smp_chan   (smp_chan)
  );

endmodule

// File: rtl/sss_checker.sv
module sss_checker #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              act,
  input logic              fall,
  input logic              rise,
  input logic [ADDR_W-1:0] addr,
  input logic              dout,
  input logic              dout_oe,
  input logic              smp_strobe,
  input logic [ADDR_W-1:0] smp_chan
);

  p_quiet_when_deselected_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> (!dout_oe && !dout));

  p_dout_moves_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !fall) |=> $stable(dout));

  p_code_changes_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(addr));

  p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_strobe |=> !smp_strobe);

  p_strobe_after_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_strobe |-> $past(fall));

  p_chan_from_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    smp_strobe |-> (smp_chan == $past(addr)));

endmodule

bind sar_serial_slave sss_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .act        (evt.act),
  .fall       (evt.fall),
  .rise       (evt.rise),
  .addr       (cur_addr),
  .dout       (dout),
  .dout_oe    (dout_oe),
  .smp_strobe (smp_strobe),
  .smp_chan   (smp_chan)
);

// File: tb/tb_sar_serial_slave.sv
`timescale 1ns/1ps
module tb_sar_serial_slave;

  localparam int HALF = 4;  // system clocks per serial half period

  logic        clk = 1'b0;
  logic        rst_n, cs_n, sclk, din;
  logic [83:0] chan_data;
  logic        dout, dout_oe, smp_strobe;
  logic [2:0]  smp_chan;

  int checks = 0;
  int errs   = 0;
  int stb_seen = 0;
  bit done = 0;
  logic [2:0] cur;  // channel code governing the current frame

  always #2.5 clk = ~clk;

  sar_serial_slave dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .chan_data(chan_data), .dout(dout), .dout_oe(dout_oe),
    .smp_strobe(smp_strobe), .smp_chan(smp_chan)
  );

  always @(negedge clk) if (smp_strobe === 1'b1) stb_seen++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act_v, input logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act_v, exp_v);
    end
  endtask

  function automatic logic [11:0] pat(input int ch, input int seed);
    if (seed == 99) return 12'hFFF;
    if (seed == 98) return 12'h000;
    return 12'((ch * 667 + seed * 455 + 243) & 4095);
  endfunction

  task automatic load_data(input int seed);
    for (int c = 0; c < 7; c++) chan_data[c*12 +: 12] = pat(c, seed);
  endtask

  function automatic logic [11:0] expect_word(input logic [2:0] a, input int seed);
    return (a == 3'd7) ? 12'h000 : pat(int'(a), seed);
  endfunction

  // Select falls; on return falling edge 1 has occurred.
  task automatic open_frame(input bit idle_low);
    sclk = idle_low ? 1'b0 : 1'b1;
    tick(HALF);
    cs_n = 1'b0;
    if (!idle_low) begin
      tick(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic close_frame();
    tick(HALF);
    cs_n = 1'b1;
    tick(6);
    chk("R8", "dout_oe after select rise", 32'(dout_oe), 32'd0);
  endtask

  // One frame body after its falling edge 1; ends with the clock high.
  task automatic conv(input logic [2:0] nxt, input int seed, input logic [7:0] junk,
                      input int late_seed, input string req);
    logic [7:0]  cmd;
    logic [15:0] w;
    int          s0;
    cmd = {2'($urandom), nxt, 3'($urandom)};
    s0  = stb_seen;
    load_data(late_seed >= 0 ? seed + 50 : seed);
    for (int i = 0; i < 16; i++) begin
      din = (i < 8) ? cmd[7-i] : junk[15-i];
      if (i == 2) load_data(seed);          // just before falling edge 4
      tick(HALF);
      if (i == 3 && late_seed >= 0) load_data(late_seed);  // after the hold point
      w[15-i] = dout;
      sclk = 1'b1;
      tick(HALF);
      if (i < 15) sclk = 1'b0;
    end
    chk(req, "serial word", 32'(w), 32'({4'b0000, expect_word(cur, seed)}));
    chk("R7", "strobes per frame", 32'(stb_seen - s0), 32'd1);
    chk("R7", "smp_chan", 32'(smp_chan), 32'(cur));
    cur = nxt;
  endtask

  // Select rises after n rising edges of a frame.
  task automatic abort_frame(input bit idle_low, input logic [2:0] bad, input int n);
    logic [7:0] cmd;
    cmd = {2'b10, bad, 3'b011};
    open_frame(idle_low);
    for (int i = 0; i < n; i++) begin
      din = cmd[7-i];
      tick(HALF);
      sclk = 1'b1;
      tick(HALF);
      if (i < n - 1) sclk = 1'b0;
    end
    tick(2);
    cs_n = 1'b1;
    tick(6);
  endtask

  initial begin
    cs_n = 1'b1; sclk = 1'b0; din = 1'b0; chan_data = '0; rst_n = 1'b0;
    cur = 3'd0;
    tick(5);
    rst_n = 1'b1;
    tick(4);
    chk("R6", "dout_oe after reset", 32'(dout_oe), 32'd0);
    chk("R6", "dout after reset", 32'(dout), 32'd0);
    chk("R6", "smp_strobe after reset", 32'(smp_strobe), 32'd0);

    // Continuous frames sweeping every code; first frame shows code 0.
    open_frame(1'b1);
    tick(4);
    chk("R8", "dout_oe inside frame", 32'(dout_oe), 32'd1);
    for (int k = 0; k < 9; k++) begin
      if (k > 0) sclk = 1'b0;  // falling edge 1 of the next frame
      conv(3'((k * 5 + 2) % 8), k, 8'(k * 37), -1, "R1 R2 R4 R5 R6");
    end
    close_frame();

    // Separate frames, clock idling high, late din set to look like other codes.
    for (int k = 0; k < 4; k++) begin
      open_frame(1'b0);
      conv(3'((k * 3 + 1) % 8), 10 + k, (k % 2 == 0) ? 8'hFF : 8'h28, -1, "R9 R3 R5");
      close_frame();
    end

    // Clock idling low: select fall is edge 1.
    open_frame(1'b1);
    conv(3'd3, 15, 8'hA5, -1, "R9");
    close_frame();

    // Capture point: data swapped just after falling edge 4 must not show.
    open_frame(1'b1);
    conv(3'd6, 20, 8'h00, 21, "R7");
    close_frame();

    // Aborted commands leave code 6 in force; next frame realigned.
    abort_frame(1'b1, 3'd1, 5);
    open_frame(1'b1);
    conv(3'd2, 30, 8'h3C, -1, "R10");
    close_frame();
    abort_frame(1'b0, 3'd5, 7);
    abort_frame(1'b1, 3'd4, 2);
    open_frame(1'b0);
    conv(3'd0, 31, 8'h00, -1, "R10");
    close_frame();

    // Activity while deselected is ignored.
    for (int t = 0; t < 12; t++) begin
      din = t[0];
      sclk = ~sclk;
      tick(HALF);
      chk("R8", "dout_oe while deselected", 32'(dout_oe), 32'd0);
      chk("R8", "dout while deselected", 32'(dout), 32'd0);
    end
    open_frame(1'b0);
    conv(3'd1, 40, 8'hFF, -1, "R8");
    close_frame();

    // Extreme data words, back to back.
    open_frame(1'b1);
    conv(3'd4, 99, 8'h00, -1, "R2 R4");
    sclk = 1'b0;
    conv(3'd7, 99, 8'hFF, -1, "R2 R4");
    sclk = 1'b0;
    conv(3'd0, 98, 8'hFF, -1, "R2 R4");
    sclk = 1'b0;
    conv(3'd0, 99, 8'h00, -1, "R2 R4");
    close_frame();

    done = 1;
  end

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

endmodule